// File: doc/BRIEF.md
# Cycle Profiler and Event Trace Recorder

This block runs beside a piece of user logic and measures how it behaves at runtime, so that host software can read the results back without halting the design. It watches the current state code of a monitored state machine and a small group of event trigger lines. It keeps a 64-bit count of running cycles and one counter for each monitored state. Each time a trigger fires, it stores a 96-bit timestamped record in an on-chip trace memory.

The host drives three command strobes (start, stop, clear) and a read port with a small address space. Reads return profile counters, the cycle count, a count of lost trace records and sticky per-counter wrap flags. Reading one particular address pops the trace memory one 32-bit slice at a time. Reads are allowed while measurement is running. The block leaves reset stopped and does nothing until the host starts it.

Top module: `prof_trace_mon`

## Requirements
- R1: After reset the block is stopped, every counter, flag and the lost-record count reads zero, and a trace pop returns zero.
- R2: Counting and trace capture happen only while running; start sets running, stop clears it (stop wins if both are strobed), and while stopped the cycle count, profile counters and trace memory do not change.
- R3: On each running cycle the profile counter selected by `state_in` increases by one; counter k reads at address k (0x00 to 0x0F), zero-extended to 32 bits.
- R4: A 64-bit cycle counter increases by one on each running cycle; its low half reads at 0x10 and its high half at 0x11.
- R5: On a running cycle with any trigger line high, a record {cycle[63:32], cycle[31:0], cap_data} (bits 95:64, 63:32, 31:0) is stored, the cycle value being the count before that cycle's increment; each read of 0x14 returns the oldest record's bits 31:0, then 63:32, then 95:64, after which that record is removed; a pop with no record held returns zero and changes nothing.
- R6: The trace memory holds 64 records; a capture that finds it full is discarded and the lost-record count at 0x12 increases by one.
- R7: A capture and the pop of a record's last slice in the same cycle both take effect, even when the memory is full.
- R8: When a profile counter wraps from all ones to zero, bit k of the flag word at 0x13 is set for counter k and stays set until clear.
- R9: The clear strobe zeroes the cycle count, all profile counters, the flags, the lost-record count and the trace pointers in one cycle, and leaves the run state unchanged.
- R10: Read data appears on `rd_data` with `rd_valid` high one cycle after `rd_en`, holding the value the register had before that edge; unused addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_in | input | 4 | State code of the monitored state machine |
| trig_in | input | 4 | Event trigger lines, any high requests a record |
| cap_data | input | 32 | Data word captured into a record |
| cmd_start | input | 1 | Start measurement |
| cmd_stop | input | 1 | Stop measurement |
| cmd_clear | input | 1 | Zero counters, statistics and trace pointers |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |

## Verification
The case that matters is a trigger arriving in the very cycle the host pops the final slice of the oldest record while the memory is full. The bench fills the memory with 64 captures, forces a few drops, pops two slices of the head record, and then raises a trigger during the third pop. The lost-record count must not move, and the new record must later come out as the last one. A second overlap, reading counters while they keep counting, is judged against an arithmetic model stepped alongside the design.

// File: rtl/prof_trace_mon.sv
module prof_trace_mon #(
  parameter int NST   = 16,
  parameter int PCW   = 32,
  parameter int DEPTH = 64,
  parameter int NTRIG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NST)-1:0]   state_in,
  input  logic [NTRIG-1:0]         trig_in,
  input  logic [31:0]              cap_data,
  input  logic                     cmd_start,
  input  logic                     cmd_stop,
  input  logic                     cmd_clear,
  input  logic                     rd_en,
  input  logic [4:0]               rd_addr,
  output logic [31:0]              rd_data,
  output logic                     rd_valid
);
  localparam int SW = $clog2(NST);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [4:0] A_CYCLO = 5'h10;
  localparam logic [4:0] A_CYCHI = 5'h11;
  localparam logic [4:0] A_DROP  = 5'h12;
  localparam logic [4:0] A_OVF   = 5'h13;
  localparam logic [4:0] A_POP   = 5'h14;

  logic           run_q;
  logic [63:0]    cyc_q;
  logic [PCW-1:0] prof_q [NST];
  logic [NST-1:0] ovf_q;
  logic [31:0]    drop_q;
  logic [95:0]    mem [DEPTH];
  logic [PW-1:0]  wp_q, rp_q;
  logic [1:0]     sl_q;
  logic [31:0]    rd_mux;
  logic [95:0]    head;

  wire empty    = (wp_q == rp_q);
  wire full     = ((wp_q - rp_q) == PW'(DEPTH));
  wire pop      = rd_en && (rd_addr == A_POP) && !empty;
  wire pop_done = pop && (sl_q == 2'd2);
  wire push_req = run_q && |trig_in;
  wire room     = !full || pop_done;
  wire push     = push_req && room && !cmd_clear;

  assign head = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= 1'b0;
    else if (cmd_stop)  run_q <= 1'b0;
    else if (cmd_start) run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_clear) begin
      cyc_q  <= '0;
      ovf_q  <= '0;
      drop_q <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      sl_q   <= '0;
      for (int k = 0; k < NST; k++) prof_q[k] <= '0;
    end else begin
      if (run_q) begin
        cyc_q <= cyc_q + 64'd1;
        prof_q[state_in] <= prof_q[state_in] + 1'b1;
        if (&prof_q[state_in]) ovf_q[state_in] <= 1'b1;
      end
      if (push_req && !room) drop_q <= drop_q + 32'd1;
      if (push) wp_q <= wp_q + 1'b1;
      if (pop_done) begin
        rp_q <= rp_q + 1'b1;
        sl_q <= 2'd0;
      end else if (pop) begin
        sl_q <= sl_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[AW-1:0]] <= {cyc_q, cap_data};
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr < 5'(NST)) rd_mux = 32'(prof_q[rd_addr[SW-1:0]]);
    else begin
      case (rd_addr)
        A_CYCLO: rd_mux = cyc_q[31:0];
        A_CYCHI: rd_mux = cyc_q[63:32];
        A_DROP:  rd_mux = drop_q;
        A_OVF:   rd_mux = 32'(ovf_q);
        A_POP:   if (!empty) begin
          case (sl_q)
            2'd0:    rd_mux = head[31:0];
            2'd1:    rd_mux = head[63:32];
            default: rd_mux = head[95:64];
          endcase
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_clear) |=> $stable(cyc_q)) else $error("stop freeze"); // R2
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q - rp_q) <= PW'(DEPTH)) else $error("pointer bound"); // R6
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_done && !cmd_clear) |=> (drop_q == $past(drop_q) + 32'd1))
    else $error("drop count"); // R6
  AST_JOINT_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_done) |=> ((wp_q - rp_q) == $past(wp_q - rp_q))) else $error("joint"); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (cyc_q == 64'd0 && drop_q == 32'd0 && ovf_q == '0 && wp_q == rp_q))
    else $error("clear"); // R9
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid) else $error("read valid"); // R10
endmodule

// File: tb/tb_prof_trace_mon.sv
module tb_prof_trace_mon;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 8;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic [3:0] state_in = 0, trig_in = 0;
  logic [31:0] cap_data = 0;
  logic cmd_start = 0, cmd_stop = 0, cmd_clear = 0, rd_en = 0;
  logic [4:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic rd_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  prof_trace_mon #(.PCW(PCW), .DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // arithmetic model
  bit m_run;
  logic [63:0] m_cyc;
  int unsigned m_prof [16];
  logic [15:0] m_ovf;
  int unsigned m_drop;
  logic [95:0] m_fifo [DEPTH];
  int m_wp, m_rp, m_sl;
  logic [31:0] exp_rd;

  function automatic logic [31:0] model_read(logic [4:0] a);
    logic [95:0] h;
    if (a < 16) return m_prof[a];
    case (a)
      5'h10: return m_cyc[31:0];
      5'h11: return m_cyc[63:32];
      5'h12: return m_drop;
      5'h13: return {16'd0, m_ovf};
      5'h14: begin
        if (m_wp == m_rp) return 0;
        h = m_fifo[m_rp % DEPTH];
        return (m_sl == 0) ? h[31:0] : (m_sl == 1) ? h[63:32] : h[95:64];
      end
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_run = 0; m_cyc = 0; m_ovf = 0; m_drop = 0; m_wp = 0; m_rp = 0; m_sl = 0;
    for (int k = 0; k < 16; k++) m_prof[k] = 0;
  endtask

  task automatic tick(input string tag);
    bit popd, pop, room;
    bit old_run;
    @(posedge clk);
    exp_rd = model_read(rd_addr);
    old_run = m_run;
    if (cmd_stop) m_run = 0; else if (cmd_start) m_run = 1;
    if (cmd_clear) begin
      m_cyc = 0; m_ovf = 0; m_drop = 0; m_wp = 0; m_rp = 0; m_sl = 0;
      for (int k = 0; k < 16; k++) m_prof[k] = 0;
    end else begin
      pop = rd_en && rd_addr == 5'h14 && m_wp != m_rp;
      popd = pop && m_sl == 2;
      room = (m_wp - m_rp) < DEPTH || popd;
      if (old_run && trig_in != 0) begin
        if (room) begin m_fifo[m_wp % DEPTH] = {m_cyc, cap_data}; m_wp++; end
        else m_drop++;
      end
      if (old_run) begin
        m_cyc++;
        if (m_prof[state_in] == (1 << PCW) - 1) begin m_prof[state_in] = 0; m_ovf[state_in] = 1; end
        else m_prof[state_in]++;
      end
      if (popd) begin m_rp++; m_sl = 0; end else if (pop) m_sl++;
    end
    @(negedge clk);
    if (rd_en) begin
      checks++;
      if (rd_data !== exp_rd || rd_valid !== 1'b1) begin
        errors++;
        $display("FAIL %s addr %0h actual %0h valid %0b expected %0h", tag, rd_addr, rd_data, rd_valid, exp_rd);
      end
    end
    cmd_start = 0; cmd_stop = 0; cmd_clear = 0; rd_en = 0; trig_in = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    rd_en = 1; rd_addr = a; tick(tag);
  endtask

  task automatic expect_val(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual %0h expected %0h", tag, act, exp); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 21; a++) rd(5'(a), "R1");
    // R2 stopped: triggers and cycles ignored
    for (int i = 0; i < 5; i++) begin trig_in = 4'h1; cap_data = 32'hdead; tick("R2"); end
    rd(5'h10, "R2"); rd(5'h14, "R2"); rd(5'h12, "R2");
    // R3 state sweep with running counts
    cmd_start = 1; tick("R2");
    for (int s = 0; s < 16; s++) begin
      state_in = 4'(s);
      for (int j = 0; j <= s; j++) tick("R3");
    end
    state_in = 4'd15; cmd_stop = 1; tick("R2");
    for (int s = 0; s < 16; s++) begin
      rd(5'(s), "R3");
      expect_val(rd_data, (s == 15) ? 32'd17 : 32'(s + 1), "R3");
    end
    rd(5'h10, "R4");
    expect_val(rd_data, 32'd137, "R4");
    rd(5'h11, "R4");
    // R8 overflow: 8-bit counter 3 wraps
    cmd_start = 1; tick("R2");
    state_in = 4'd3;
    for (int i = 0; i < 300; i++) tick("R8");
    cmd_stop = 1; tick("R2");
    rd(5'h13, "R8"); rd(5'd3, "R8");
    expect_val({16'd0, m_ovf}, 32'h8, "R8");
    // R10 read while running
    cmd_start = 1; tick("R2");
    for (int i = 0; i < 4; i++) rd(5'h10, "R10");
    rd(5'h1f, "R10");
    // R9 clear while running keeps running
    cmd_clear = 1; tick("R9");
    rd(5'h10, "R9"); rd(5'h13, "R9"); rd(5'd3, "R9"); rd(5'h12, "R9");
    // R5/R6 fill trace memory and overflow it
    for (int i = 0; i < DEPTH + 3; i++) begin
      trig_in = 4'(1 << (i % 4)); cap_data = 32'(i * 7 + 5); tick("R5");
    end
    rd(5'h12, "R6");
    expect_val(rd_data, 32'd3, "R6");
    // R7 capture during final-slice pop while full
    rd(5'h14, "R7"); rd(5'h14, "R7");
    trig_in = 4'h8; cap_data = 32'hcafe0001; rd(5'h14, "R7");
    rd(5'h12, "R7");
    expect_val(rd_data, 32'd3, "R7");
    cmd_stop = 1; tick("R2");
    // drain remaining 64 records
    for (int i = 0; i < DEPTH * 3; i++) rd(5'h14, "R5");
    expect_val(rd_data, 32'(0), "R5");
    rd(5'h14, "R5");
    expect_val(rd_data, 32'd0, "R5");
    // R5 record for a running trigger, bit order
    cmd_clear = 1; cmd_start = 1; tick("R9");
    for (int i = 0; i < 9; i++) tick("R5");
    trig_in = 4'h2; cap_data = 32'h12345678; tick("R5");
    cmd_stop = 1; tick("R2");
    rd(5'h14, "R5"); expect_val(rd_data, 32'h12345678, "R5");
    rd(5'h14, "R5"); expect_val(rd_data, 32'd9, "R5");
    rd(5'h14, "R5"); expect_val(rd_data, 32'd0, "R5");
    rd(5'h14, "R5");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule